// File: doc/BRIEF.md
# Burst Error and Erasure Channel Emulator

This block sits inline in a byte-wide symbol stream and imitates a two-state channel. In the good state it passes symbols untouched. In the bad state it corrupts a cluster of consecutive symbols. A free-running pseudorandom register decides, one symbol at a time, whether a burst begins. The chance is about one half per idle symbol, so the gaps between bursts vary. Once a burst has begun, it lasts for a fixed, programmable number of symbols.

Two kinds of corruption are available. In error mode, each symbol inside a burst is XORed with a byte taken from a second pseudorandom register. In erasure mode, each symbol inside a burst is replaced by zero. The output is combinational from the input, so corrupted symbols come out in the same cycle with no added latency. All internal state moves forward only on cycles that carry a valid symbol.

Top module: `burst_channel_emu`

## Requirements
- R1: `out_valid` equals `in_valid` in every cycle, and the block has no latency: each symbol's result appears on `out_data` in the same cycle as the symbol.
- R2: A valid symbol that is not part of a burst appears on `out_data` unchanged. When `in_valid` is low, `out_data` equals `in_data`.
- R3: A burst can begin only on a valid symbol that arrives while no burst is active, and it begins when bit 0 of the trigger register is 1. That symbol is the first symbol of the burst. The trigger register is 8 bits wide and steps as next = {s[6:0], s[7]^s[3]^s[2]^s[1]}.
- R4: A length code n on `len_code` (0 to 15) gives a burst of exactly n+1 consecutive valid symbols. The next valid symbol after the burst is not corrupted by that burst.
- R5: When `err_mode` is 1, each burst symbol is output as `in_data` XOR the current value of the noise register. The noise register is 8 bits wide and steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R6: When `err_mode` is 0, each burst symbol is output as 8'h00.
- R7: The mode and the length code are taken on the first symbol of a burst. Changes to either input during the burst have no effect until the burst ends. Triggers are ignored while a burst is active.
- R8: On a cycle with `in_valid` low, both pseudorandom registers and the burst state keep their values.
- R9: While `rst_n` is low, the block returns to the good state, the noise register is loaded with 8'hA5 and the trigger register is loaded with 8'h1C. Because bit 0 of the trigger seed is 0, the first valid symbol after reset is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol strobe: the symbol on `in_data` is valid this cycle |
| in_data | input | 8 | Input symbol |
| err_mode | input | 1 | 1 = XOR with a pseudorandom byte (error mode), 0 = zero the symbol (erasure mode) |
| len_code | input | 4 | Burst length code; a burst lasts code+1 symbols |
| out_valid | output | 1 | Output symbol valid |
| out_data | output | 8 | Output symbol, passed through or corrupted |

## Verification
The assertions check on every cycle that:
- state holds across cycles without a symbol;
- symbols outside a burst pass through unchanged;
- erased symbols come out as zero;
- the burst counter stays within the latched length and the burst closes when the counter reaches it;
- the latched mode and length stay steady for the whole burst.

Only the bench scenarios can show the exact pseudorandom XOR values, where each burst starts, and which symbol a burst begins on. The bench compares every symbol against a model built from the stated polynomials and seeds. The scenarios cover both modes, the shortest and the longest bursts, mode and length changes in the middle of a burst, gaps without symbols, and a reset in the middle of a burst.

// File: rtl/burst_channel_emu.sv
module burst_channel_emu #(
  parameter logic [7:0] NOISE_SEED = 8'hA5,
  parameter logic [7:0] TRIG_SEED  = 8'h1C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       err_mode,
  input  logic [3:0] len_code,
  output logic       out_valid,
  output logic [7:0] out_data
);

  logic [7:0] noise_q, trig_q;
  logic       busy, mode_q;
  logic [3:0] cnt, len_q;

  wire start    = in_valid && !busy && trig_q[0];
  wire hit      = start || (busy && in_valid);
  wire mode_now = busy ? mode_q : err_mode;

  assign out_valid = in_valid;
  assign out_data  = !hit ? in_data : (mode_now ? (in_data ^ noise_q) : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      noise_q <= NOISE_SEED;
      trig_q  <= TRIG_SEED;
      busy    <= 1'b0;
      mode_q  <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
    end else if (in_valid) begin
      noise_q <= {noise_q[6:0], noise_q[7] ^ noise_q[5] ^ noise_q[4] ^ noise_q[3]};
      trig_q  <= {trig_q[6:0],  trig_q[7]  ^ trig_q[3]  ^ trig_q[2]  ^ trig_q[1]};
      if (start) begin
        if (len_code != 4'd0) begin
          busy   <= 1'b1;
          cnt    <= 4'd1;
          len_q  <= len_code;
          mode_q <= err_mode;
        end
      end else if (busy) begin
        if (cnt == len_q) busy <= 1'b0;
        else              cnt  <= cnt + 4'd1;
      end
    end
  end

endmodule

module burst_channel_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic [7:0] out_data,
  input logic       hit,
  input logic       busy,
  input logic       mode_q,
  input logic [3:0] cnt,
  input logic [3:0] len_q,
  input logic [7:0] noise_q,
  input logic [7:0] trig_q
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(busy) && $stable(cnt) && $stable(noise_q) && $stable(trig_q));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hit |-> out_data == in_data);

  p_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && busy && !mode_q |-> out_data == 8'h00);

  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != 4'd0) && (cnt <= len_q));

  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && busy && cnt == len_q |=> !busy);

  p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(len_q) && $stable(mode_q));

endmodule

bind burst_channel_emu burst_channel_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_data(out_data), .hit(hit), .busy(busy), .mode_q(mode_q),
  .cnt(cnt), .len_q(len_q), .noise_q(noise_q), .trig_q(trig_q)
);

// File: tb/test_burst_channel_emu.sv
module test_burst_channel_emu;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, err_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] len_code = '0;
  logic out_valid;
  logic [7:0] out_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state, built from the stated polynomials and seeds
  logic [7:0] m_noise, m_trig;
  logic       m_busy, m_mode;
  logic [3:0] m_cnt, m_len;

  burst_channel_emu i_burst_channel_emu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .err_mode(err_mode), .len_code(len_code),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(PERIOD/2) clk = ~clk;

  // fields: [13] valid, [12] mode, [11:8] length code, [7:0] data
  localparam logic [13:0] VEC [20] = '{
    {1'b1,1'b1,4'd0,8'h11}, {1'b1,1'b1,4'd0,8'h22}, {1'b1,1'b1,4'd2,8'h33},
    {1'b1,1'b1,4'd2,8'h44}, {1'b0,1'b0,4'd5,8'h55}, {1'b1,1'b0,4'd3,8'h66},
    {1'b1,1'b0,4'd3,8'h77}, {1'b1,1'b0,4'd3,8'h88}, {1'b1,1'b0,4'd3,8'h99},
    {1'b1,1'b1,4'd1,8'hAA}, {1'b0,1'b1,4'd1,8'hBB}, {1'b1,1'b1,4'd1,8'hCC},
    {1'b1,1'b0,4'd4,8'hDD}, {1'b1,1'b0,4'd4,8'hEE}, {1'b1,1'b1,4'd4,8'hFF},
    {1'b1,1'b1,4'd0,8'h01}, {1'b1,1'b0,4'd0,8'h02}, {1'b1,1'b1,4'd6,8'h03},
    {1'b1,1'b1,4'd6,8'h04}, {1'b1,1'b0,4'd6,8'h05}
  };

  task automatic model_reset();
    m_noise = 8'hA5; m_trig = 8'h1C; m_busy = 0; m_mode = 0; m_cnt = 0; m_len = 0;
  endtask

  task automatic check(input string tag, input logic [7:0] exp_d, input logic exp_v);
    n_vec++;
    if (out_valid !== exp_v || out_data !== exp_d) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b out_data=%02h expected %0b %02h",
               tag, out_valid, out_data, exp_v, exp_d);
    end
  endtask

  task automatic apply(input string phase, input logic v, input logic m,
                       input logic [3:0] l, input logic [7:0] d);
    logic st, h, mn;
    logic [7:0] e;
    string cls;
    @(negedge clk);
    in_valid = v; err_mode = m; len_code = l; in_data = d;
    #2;
    st = v && !m_busy && m_trig[0];
    h  = st || (m_busy && v);
    mn = m_busy ? m_mode : m;
    if (!h)     begin e = d;           cls = v ? "R2" : "R1"; end
    else if (mn) begin e = d ^ m_noise; cls = "R5"; end
    else         begin e = 8'h00;       cls = "R6"; end
    check({phase, "/", cls}, e, v);
    if (v) begin
      if (st) begin
        if (l != 0) begin m_busy = 1; m_cnt = 1; m_len = l; m_mode = m; end
      end else if (m_busy) begin
        if (m_cnt == m_len) m_busy = 0; else m_cnt++;
      end
      m_noise = {m_noise[6:0], m_noise[7]^m_noise[5]^m_noise[4]^m_noise[3]};
      m_trig  = {m_trig[6:0],  m_trig[7]^m_trig[3]^m_trig[2]^m_trig[1]};
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: idle after reset, first symbol passes
    #2; check("R9 idle", in_data, 1'b0);
    apply("R9 first", 1, 1, 4'd3, 8'h5A);
    if (m_busy) $display("note: unexpected model start");

    // R3 R5 R6: table walk
    for (int i = 0; i < 20; i++)
      apply("R3", VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:0]);

    // R4: longest bursts, error mode
    for (int i = 0; i < 60; i++) apply("R4 len15", 1, 1, 4'd15, 8'(i*7));
    // R4: single-symbol bursts, erasure
    for (int i = 0; i < 30; i++) apply("R4 len0", 1, 0, 4'd0, 8'(i+100));
    // R7: mode and length change on every symbol
    for (int i = 0; i < 50; i++) apply("R7", 1, i[0], 4'(i*5), 8'(255-i));
    // R8: symbol gaps
    for (int i = 0; i < 50; i++) apply("R8", i%3 != 0, i[1], 4'd6, 8'(i*13));

    // R9: reset in the middle of a long burst
    for (int i = 0; i < 6; i++) apply("R9 pre", 1, 0, 4'd15, 8'hC3);
    do_reset();
    apply("R9 after", 1, 0, 4'd15, 8'hC3);
    for (int i = 0; i < 20; i++) apply("R9 run", 1, 1, 4'd2, 8'(i));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule